// File: doc/BRIEF.md
# Byte-Stream Command Decoder with GPIO

This block sits behind a byte pipe and reads it as a command language for two 8-bit pin banks. Each opcode byte with bit 7 set is decoded here. It is followed by zero, one or two parameter bytes. The commands set a bank's output values and pin directions and sample a bank's pins into a response stream. Other commands turn the loopback flag on and off, load a 16-bit clock divisor, choose pins that float instead of driving a 1, and hold off further commands until a wait pin reaches a chosen level. A final command releases the response bytes that have collected.

Responses do not leave the block one at a time. They gather in a small response buffer and go out when a flush opcode arrives, or on their own once the buffer is nearly full. Any byte with bit 7 clear starts a data transfer. That byte, and every byte after it, is handed unchanged to an external shift engine until the engine reports that it is done. Parsing then resumes at the next byte.

Top module: `cmd_gpio_decoder`

## Requirements
- R1: After reset, both banks have all pins as inputs (output enables 0) with output values 0, the loopback flag is off, the divisor is 0, no response byte is offered and the input stream is ready.
- R2: Opcode 0x80 (low bank) or 0x82 (high bank) takes a value byte and then a direction byte. After the direction byte is accepted, the bank's output values equal the value byte and each direction bit of 1 enables that pin's driver.
- R3: Opcode 0x81 or 0x83 places one response byte equal to the low or high bank's input pins, sampled in the cycle the opcode is accepted.
- R4: Response bytes are held back, with out_valid low, until opcode 0x87 is accepted; they then all go out in order. When the buffer holds RSP_DEPTH-1 bytes (7 by default) they go out without a flush.
- R5: Opcode 0x84 sets loopback_en and 0x85 clears it.
- R6: Opcode 0x86 takes two bytes, low byte first, and clk_div becomes their 16-bit value.
- R7: Opcode 0x88 (or 0x89) stops the decoder accepting bytes until lo_in[WAIT_BIT] (bit 1 by default) is 1 (or 0). The next byte is then accepted and executed.
- R8: Opcode 0x9E takes a mask, low-bank byte first and then high-bank byte. A masked output pin whose value is 1 has its driver disabled. A masked pin with value 0 keeps driving.
- R9: An opcode with bit 7 set that is not listed here produces the response bytes 0xFA and then the opcode. The next byte is decoded as an opcode.
- R10: A byte with bit 7 clear, and every later byte, is forwarded on xfer_data/xfer_valid until xfer_done is seen. Forwarded bytes never change pins or settings, and decoding resumes afterwards.
- R11: While out_valid is high and out_ready is low, out_valid stays high and out_data stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Command/parameter byte |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Decoder accepts in_data this cycle |
| out_data | output | 8 | Response byte |
| out_valid | output | 1 | Response byte offered |
| out_ready | input | 1 | Consumer takes the response byte |
| xfer_data | output | 8 | Byte forwarded to the shift engine |
| xfer_valid | output | 1 | xfer_data is valid |
| xfer_ready | input | 1 | Shift engine accepts xfer_data |
| xfer_done | input | 1 | Shift engine returns the stream to the decoder |
| lo_in | input | 8 | Low bank pin levels |
| lo_out | output | 8 | Low bank output values |
| lo_oe | output | 8 | Low bank driver enables |
| hi_in | input | 8 | High bank pin levels |
| hi_out | output | 8 | High bank output values |
| hi_oe | output | 8 | High bank driver enables |
| loopback_en | output | 1 | Loopback flag for the shift engine |
| clk_div | output | 16 | Clock divisor |

## Verification
The assertions assume the input side keeps in_data steady while in_valid is high and in_ready is low. They also assume xfer_done is raised only while a transfer owns the stream. The response-overflow guard relies on the decoder asking for two free slots before it takes any opcode. The bench drives bytes one handshake at a time and pulses xfer_done only after a transfer has started. It changes out_ready and the pin inputs only just after a rising edge, so each wait-pin and backpressure case falls on a known cycle.

// File: rtl/cgd_pkg.sv
// Shared opcodes and parser states for the command decoder.
// Assumes 8-bit command bytes; opcodes with bit 7 clear belong to the shift engine.
package cgd_pkg;
    localparam logic [7:0] OP_SET_LO  = 8'h80;
    localparam logic [7:0] OP_RD_LO   = 8'h81;
    localparam logic [7:0] OP_SET_HI  = 8'h82;
    localparam logic [7:0] OP_RD_HI   = 8'h83;
    localparam logic [7:0] OP_LB_ON   = 8'h84;
    localparam logic [7:0] OP_LB_OFF  = 8'h85;
    localparam logic [7:0] OP_DIV     = 8'h86;
    localparam logic [7:0] OP_FLUSH   = 8'h87;
    localparam logic [7:0] OP_WAIT_HI = 8'h88;
    localparam logic [7:0] OP_WAIT_LO = 8'h89;
    localparam logic [7:0] OP_FLOAT   = 8'h9E;
    localparam logic [7:0] ERR_MARK   = 8'hFA;

    typedef enum logic [2:0] {
        ST_OP,
        ST_P1,
        ST_P2,
        ST_WAIT,
        ST_ERR,
        ST_PASS
    } pstate_t;
endpackage

// File: rtl/cgd_pin_bank.sv
// One GPIO bank: value, direction and float-on-one mask registers.
// Assumes the strobes are single-cycle and come from the parser.
module cgd_pin_bank #(
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic [PIN_W-1:0] val_in,
    input  logic [PIN_W-1:0] dir_in,
    input  logic             mask_stb,
    input  logic [PIN_W-1:0] mask_in,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe
);
    logic [PIN_W-1:0] val_q, dir_q, mask_q;

    // Holds the bank configuration written by the parser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else begin
            if (set_stb) begin
                val_q <= val_in;
                dir_q <= dir_in;
            end
            if (mask_stb) mask_q <= mask_in;
        end
    end

    // Output pins drive only where direction is out and no float-on-one applies.
    always_comb begin
        pin_out = val_q;
        pin_oe  = dir_q & ~(mask_q & val_q);
    end
endmodule

// File: rtl/cgd_rsp_fifo.sv
// Response buffer that holds bytes until a flush or until nearly full.
// Assumes DEPTH is a power of two and the writer checks room before pushing.
module cgd_rsp_fifo #(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       flush,
    output logic       room,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       out_ready
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
    localparam logic [AW:0] CNT_HIGH = (AW+1)'(DEPTH - 1);
    localparam logic [AW:0] CNT_ROOM = (AW+1)'(DEPTH - 2);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count, count_n;
    logic          drain_q, pop;

    assign pop       = out_valid && out_ready;
    assign out_valid = drain_q && (count != '0);
    assign out_data  = mem[rd_ptr];
    assign room      = (count <= CNT_ROOM);

    // Next occupancy from this cycle's push and pop.
    always_comb begin
        count_n = count;
        if (push && !pop) count_n = count + 1'b1;
        else if (!push && pop) count_n = count - 1'b1;
    end

    // Stores pushed bytes.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Tracks pointers, occupancy and the release flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            drain_q <= 1'b0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count_n;
            if (flush || count_n >= CNT_HIGH) drain_q <= 1'b1;
            else if (count_n == '0)           drain_q <= 1'b0;
        end
    end

    // R4
    rsp_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && !pop && count == CNT_FULL));

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/cgd_parser.sv
// Command parser: decodes opcodes, gathers parameters, stalls on the wait pin
// and hands data-transfer streams to the shift engine.
// Assumes in_data is held while in_valid is high and in_ready low.
module cgd_parser
    import cgd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic        rsp_room,
    output logic        rsp_push,
    output logic [7:0]  rsp_data,
    output logic        flush_req,
    output logic [1:0]  set_stb,
    output logic        mask_stb,
    output logic [7:0]  par_a,
    output logic [7:0]  par_b,
    input  logic [7:0]  pins_lo,
    input  logic [7:0]  pins_hi,
    input  logic        wait_pin,
    output logic        loopback_en,
    output logic [15:0] clk_div,
    output logic [7:0]  xfer_data,
    output logic        xfer_valid,
    input  logic        xfer_ready,
    input  logic        xfer_done
);
    pstate_t    st;
    logic [7:0] op_q, p1_q;
    logic       want_q, accept, known, two_par;

    // Classifies the byte presented as an opcode.
    always_comb begin
        known   = 1'b0;
        two_par = 1'b0;
        unique case (in_data)
            OP_SET_LO, OP_SET_HI, OP_DIV, OP_FLOAT: begin known = 1'b1; two_par = 1'b1; end
            OP_RD_LO, OP_RD_HI, OP_LB_ON, OP_LB_OFF,
            OP_FLUSH, OP_WAIT_HI, OP_WAIT_LO:       known = 1'b1;
            default: ;
        endcase
    end

    // Ready depends on state; opcodes need room for two response bytes.
    always_comb begin
        unique case (st)
            ST_OP:        in_ready = in_data[7] ? rsp_room : xfer_ready;
            ST_P1, ST_P2: in_ready = 1'b1;
            ST_PASS:      in_ready = xfer_ready;
            default:      in_ready = 1'b0;
        endcase
    end

    assign accept     = in_valid && in_ready;
    assign xfer_data  = in_data;
    assign xfer_valid = in_valid && ((st == ST_OP && !in_data[7]) || st == ST_PASS);
    assign par_a      = p1_q;
    assign par_b      = in_data;
    assign flush_req  = (st == ST_OP) && accept && (in_data == OP_FLUSH);
    assign set_stb[0] = (st == ST_P2) && accept && (op_q == OP_SET_LO);
    assign set_stb[1] = (st == ST_P2) && accept && (op_q == OP_SET_HI);
    assign mask_stb   = (st == ST_P2) && accept && (op_q == OP_FLOAT);

    // Response byte source: readback, error marker, or the echoed opcode.
    always_comb begin
        rsp_push = 1'b0;
        rsp_data = ERR_MARK;
        if (st == ST_ERR) begin
            rsp_push = 1'b1;
            rsp_data = op_q;
        end else if (st == ST_OP && accept && in_data[7]) begin
            if (in_data == OP_RD_LO) begin
                rsp_push = 1'b1;
                rsp_data = pins_lo;
            end else if (in_data == OP_RD_HI) begin
                rsp_push = 1'b1;
                rsp_data = pins_hi;
            end else if (!known) begin
                rsp_push = 1'b1;
            end
        end
    end

    // Parser state machine and the settings it owns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_OP;
            op_q        <= '0;
            p1_q        <= '0;
            want_q      <= 1'b0;
            loopback_en <= 1'b0;
            clk_div     <= '0;
        end else begin
            unique case (st)
                ST_OP: if (accept) begin
                    op_q <= in_data;
                    if (!in_data[7])                                  st <= ST_PASS;
                    else if (!known)                                  st <= ST_ERR;
                    else if (two_par)                                 st <= ST_P1;
                    else if (in_data == OP_WAIT_HI || in_data == OP_WAIT_LO) begin
                        st     <= ST_WAIT;
                        want_q <= (in_data == OP_WAIT_HI);
                    end
                    if (in_data == OP_LB_ON)  loopback_en <= 1'b1;
                    if (in_data == OP_LB_OFF) loopback_en <= 1'b0;
                end
                ST_P1: if (accept) begin
                    p1_q <= in_data;
                    st   <= ST_P2;
                end
                ST_P2: if (accept) begin
                    if (op_q == OP_DIV) clk_div <= {in_data, p1_q};
                    st <= ST_OP;
                end
                ST_WAIT: if (wait_pin == want_q) st <= ST_OP;
                ST_ERR:  st <= ST_OP;
                ST_PASS: if (xfer_done) st <= ST_OP;
                default: st <= ST_OP;
            endcase
        end
    end

    // R7
    wait_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OP && accept && in_data == OP_WAIT_HI && !wait_pin) |=> !in_ready);

    // R5
    loop_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OP && accept && in_data == OP_LB_ON) |=> loopback_en);

    // R9
    err_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OP && accept && in_data[7] && !known) |=> (rsp_push && rsp_data == $past(in_data)));
endmodule

// File: rtl/cmd_gpio_decoder.sv
// Top of the byte-stream command decoder: parser, response buffer and two pin banks.
// Assumes bank width 8 because commands carry bank bytes; WAIT_BIT selects the low-bank wait pin.
module cmd_gpio_decoder #(
    parameter int RSP_DEPTH = 8,
    parameter int WAIT_BIT  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    output logic        in_ready,
    output logic [7:0]  out_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  xfer_data,
    output logic        xfer_valid,
    input  logic        xfer_ready,
    input  logic        xfer_done,
    input  logic [7:0]  lo_in,
    output logic [7:0]  lo_out,
    output logic [7:0]  lo_oe,
    input  logic [7:0]  hi_in,
    output logic [7:0]  hi_out,
    output logic [7:0]  hi_oe,
    output logic        loopback_en,
    output logic [15:0] clk_div
);
    localparam int NBANK = 2;
    localparam int BW    = 8;

    logic             rsp_room, rsp_push, flush_req, mask_stb;
    logic [7:0]       rsp_data, par_a, par_b;
    logic [NBANK-1:0] set_stb;
    logic [NBANK-1:0][BW-1:0] bank_out, bank_oe;

    cgd_parser u_parser (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .rsp_room(rsp_room), .rsp_push(rsp_push), .rsp_data(rsp_data),
        .flush_req(flush_req), .set_stb(set_stb), .mask_stb(mask_stb),
        .par_a(par_a), .par_b(par_b),
        .pins_lo(lo_in), .pins_hi(hi_in), .wait_pin(lo_in[WAIT_BIT]),
        .loopback_en(loopback_en), .clk_div(clk_div),
        .xfer_data(xfer_data), .xfer_valid(xfer_valid),
        .xfer_ready(xfer_ready), .xfer_done(xfer_done)
    );

    cgd_rsp_fifo #(.DEPTH(RSP_DEPTH)) u_rsp (
        .clk(clk), .rst_n(rst_n),
        .push(rsp_push), .push_data(rsp_data), .flush(flush_req),
        .room(rsp_room), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready)
    );

    // Bank 0 takes the first mask byte, bank 1 the second.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        cgd_pin_bank #(.PIN_W(BW)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .set_stb(set_stb[b]), .val_in(par_a), .dir_in(par_b),
            .mask_stb(mask_stb), .mask_in((b == 0) ? par_a : par_b),
            .pin_out(bank_out[b]), .pin_oe(bank_oe[b])
        );
    end

    assign lo_out = bank_out[0];
    assign lo_oe  = bank_oe[0];
    assign hi_out = bank_out[1];
    assign hi_oe  = bank_oe[1];
endmodule

// File: tb/cmd_gpio_decoder_bench.sv
module cmd_gpio_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  xfer_data;
    logic        xfer_valid;
    logic        xfer_ready = 1'b1;
    logic        xfer_done = 1'b0;
    logic [7:0]  lo_in = '0, hi_in = '0;
    logic [7:0]  lo_out, lo_oe, hi_out, hi_oe;
    logic        loopback_en;
    logic [15:0] clk_div;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [7:0] rxq[$];
    logic [7:0] xq[$];

    always #5 clk = ~clk;

    cmd_gpio_decoder u_cmd_gpio_decoder (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .xfer_data(xfer_data), .xfer_valid(xfer_valid),
        .xfer_ready(xfer_ready), .xfer_done(xfer_done),
        .lo_in(lo_in), .lo_out(lo_out), .lo_oe(lo_oe),
        .hi_in(hi_in), .hi_out(hi_out), .hi_oe(hi_oe),
        .loopback_en(loopback_en), .clk_div(clk_div)
    );

    // Records handshakes half a cycle before the edge that completes them.
    always @(negedge clk) begin
        if (out_valid && out_ready) rxq.push_back(out_data);
        if (xfer_valid && xfer_ready) xq.push_back(xfer_data);
    end

    // Watchdog ends a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        in_data  = b;
        in_valid = 1'b1;
        #1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        for (int t = 0; t < 200 && rxq.size() < n; t++) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        check("R1 lo_oe", lo_oe, 8'h00);
        check("R1 hi_oe", hi_oe, 8'h00);
        check("R1 lo_out", lo_out, 8'h00);
        check("R1 loopback", loopback_en, 1'b0);
        check("R1 clk_div", clk_div, 16'h0000);
        check("R1 out_valid", out_valid, 1'b0);
        check("R1 in_ready", in_ready, 1'b1);
    endtask

    task automatic t_banks;
        send(8'h80); send(8'hA5); send(8'h0F);
        check("R2 lo_out", lo_out, 8'hA5);
        check("R2 lo_oe", lo_oe, 8'h0F);
        check("R2 hi_oe untouched", hi_oe, 8'h00);
        send(8'h82); send(8'h3C); send(8'hF0);
        check("R2 hi_out", hi_out, 8'h3C);
        check("R2 hi_oe", hi_oe, 8'hF0);
        check("R2 lo kept", lo_out, 8'hA5);
    endtask

    task automatic t_readback;
        rxq.delete();
        lo_in = 8'h5A; hi_in = 8'hC3;
        send(8'h81);
        lo_in = 8'h00;
        send(8'h83);
        idle(5);
        check("R4 held before flush", rxq.size(), 0);
        send(8'h87);
        wait_rx(2);
        check("R4 count after flush", rxq.size(), 2);
        if (rxq.size() == 2) begin
            check("R3 low bank byte", rxq[0], 8'h5A);
            check("R3 high bank byte", rxq[1], 8'hC3);
        end
    endtask

    task automatic t_autorelease;
        rxq.delete();
        lo_in = 8'h11;
        for (int i = 0; i < 6; i++) send(8'h81);
        idle(5);
        check("R4 six held", rxq.size(), 0);
        send(8'h81);
        wait_rx(7);
        check("R4 auto release at 7", rxq.size(), 7);
        lo_in = 8'h00;
    endtask

    task automatic t_loopback;
        send(8'h84);
        check("R5 on", loopback_en, 1'b1);
        send(8'h85);
        check("R5 off", loopback_en, 1'b0);
    endtask

    task automatic t_divisor;
        send(8'h86); send(8'h34); send(8'h12);
        check("R6 divisor", clk_div, 16'h1234);
    endtask

    task automatic t_wait;
        rxq.delete();
        lo_in = 8'h00;
        send(8'h88);
        in_data = 8'h81;
        in_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R7 stalled while pin low", in_ready, 1'b0);
        end
        @(posedge clk); #1;
        lo_in = 8'h02;
        #1;
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
        send(8'h87);
        wait_rx(1);
        check("R7 resumed count", rxq.size(), 1);
        if (rxq.size() == 1) check("R7 resumed readback", rxq[0], 8'h02);
        send(8'h89);
        lo_in = 8'h00;
        idle(3);
        check("R7 low wait released", in_ready, 1'b1);
    endtask

    task automatic t_mask;
        send(8'h80); send(8'hF0); send(8'hFF);
        send(8'h82); send(8'h01); send(8'hFF);
        send(8'h9E); send(8'h30); send(8'h03);
        check("R8 low bank float on ones", lo_oe, 8'hCF);
        check("R8 high bank float", hi_oe, 8'hFE);
        send(8'h80); send(8'h0F); send(8'hFF);
        check("R8 masked zeros drive", lo_oe, 8'hFF);
    endtask

    task automatic t_unknown;
        rxq.delete();
        send(8'hB7);
        lo_in = 8'h66;
        send(8'h81);
        send(8'h87);
        wait_rx(3);
        check("R9 count", rxq.size(), 3);
        if (rxq.size() == 3) begin
            check("R9 marker", rxq[0], 8'hFA);
            check("R9 echo", rxq[1], 8'hB7);
            check("R9 next parsed", rxq[2], 8'h66);
        end
        lo_in = 8'h00;
    endtask

    task automatic t_xfer;
        logic [7:0] oe_before;
        oe_before = lo_oe;
        xq.delete();
        send(8'h19); send(8'h80); send(8'h55); send(8'h00);
        check("R10 forwarded count", xq.size(), 4);
        if (xq.size() == 4) begin
            check("R10 opcode fwd", xq[0], 8'h19);
            check("R10 data fwd", xq[1], 8'h80);
        end
        check("R10 pins untouched", lo_oe, oe_before);
        xfer_done = 1'b1;
        @(posedge clk); #1;
        xfer_done = 1'b0;
        send(8'h84);
        check("R10 parse resumed", loopback_en, 1'b1);
        check("R10 no extra fwd", xq.size(), 4);
        send(8'h85);
    endtask

    task automatic t_hold;
        rxq.delete();
        out_ready = 1'b0;
        lo_in = 8'hAB;
        send(8'h81);
        lo_in = 8'hCD;
        send(8'h81);
        send(8'h87);
        @(negedge clk);
        check("R11 valid", out_valid, 1'b1);
        check("R11 first byte", out_data, 8'hAB);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R11 held valid", out_valid, 1'b1);
            check("R11 held data", out_data, 8'hAB);
        end
        @(posedge clk); #1;
        out_ready = 1'b1;
        wait_rx(2);
        check("R11 drained", rxq.size(), 2);
        if (rxq.size() == 2) check("R11 order", rxq[1], 8'hCD);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_banks();
        t_readback();
        t_autorelease();
        t_loopback();
        t_divisor();
        t_wait();
        t_mask();
        t_unknown();
        t_xfer();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule